// File: doc/BRIEF.md
# Monitor Mode Entry Controller

This block is the mode-control unit of a small microcontroller core. Each time the part comes out of reset it settles into one of three operating modes: user mode, normal monitor mode (entered when the test-voltage detector flags the interrupt pin at reset) or forced monitor mode (entered when the core fetches a reset vector whose two bytes are both erased). While either monitor mode is active, the block moves reset and software-interrupt vector fetches one page down. This lets the core run on-chip monitor firmware in place of user code.

The block also drives the side controls that depend on the mode. It selects the clock bypass and the reset function of a shared pin while the test voltage is present. It gates the watchdog (COP) enable. It decodes two port bits into a serial or parallel host-link select. A forced-monitor flag survives general resets, and only power-on reset clears it. So once a blank part has dropped into forced monitor mode, it stays there across warm resets.

Both resets are sampled synchronously on the rising clock edge. Power-on reset takes priority over the general reset.

Top module: `monitor_entry_ctrl`

## Requirements
- R1: In either monitor mode (mode 01 or 10), a strobed fetch of address FFFE or FFFF comes out as FEFE or FEFF. Only bit 8 is cleared, and the output is combinational in the same cycle.
- R2: In either monitor mode, a strobed fetch of FFFC or FFFD comes out as FEFC or FEFD.
- R3: The address passes through unchanged in three cases: in user mode (00), when the vector-fetch strobe is low, and for any address outside FFFC..FFFF.
- R4: The mode output uses these codes: 00 user, 01 normal monitor, 10 forced monitor. After a clock edge with power-on reset high, the mode is 01 if the test voltage was present and 00 if it was not. On that same edge the forced flag is cleared.
- R5: The erased-vector check runs only in user mode. It needs two strobed fetches on back-to-back cycles: first FFFE, then FFFF, each with read data FF. When that happens, int_rst_req is high for exactly the one cycle after the FFFF fetch, and the mode becomes 10 on that same edge. In the following cases no pulse is produced and the mode stays 00: a non-FF byte in either fetch, or a gap cycle between the two fetches.
- R6: Once forced mode has been entered, a general reset with the test voltage absent returns the mode to 10. A power-on reset without the test voltage gives 00.
- R7: A general reset with the test voltage present gives mode 01, even when the forced flag is set. A later general reset without the test voltage gives 10 again.
- R8: clk_bypass and rst_pin_sel are 1 exactly while the mode is 01 and the test voltage is present. They drop as soon as the test voltage is removed.
- R9: cop_en is 0 in forced mode. It is also 0 in mode 01 while the test voltage is present. In every other case cop_en equals the inverse of cop_dis_cfg.
- R10: In either monitor mode, link_mode is decoded from port_sel as follows: 01 (serial) when port_sel is 01, 10 (parallel) whenever port_sel[1] is 1, and 00 when port_sel is 00. In user mode, link_mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| rst | input | 1 | General reset, active high, synchronous |
| tst_hv | input | 1 | Test voltage detected on the interrupt pin |
| addr_in | input | 16 | CPU address bus |
| rdata | input | 8 | Read data returned for addr_in in the same cycle |
| vec_fetch | input | 1 | Current cycle is a vector fetch |
| cop_dis_cfg | input | 1 | Configuration bit that disables the COP |
| port_sel | input | 2 | Port bits that choose the host link |
| mode | output | 2 | Current mode: 00 user, 01 normal monitor, 10 forced monitor |
| addr_out | output | 16 | Address after vector relocation |
| int_rst_req | output | 1 | One-cycle internal reset request on erased vectors |
| cop_en | output | 1 | Watchdog enable |
| clk_bypass | output | 1 | Route the external clock directly |
| rst_pin_sel | output | 1 | Shared pin acts as the reset pin |
| link_mode | output | 2 | 00 idle, 01 serial, 10 parallel |

## Verification
A corrupted mode register shows up at the ports in the same cycle. Relocated addresses, cop_en and link_mode are all combinational functions of the mode, so sweeping every vector slot and every control combination in each mode exposes it at once. A lost or spurious forced flag stays hidden until the next general reset, when the reported mode lands on the wrong code. This is why each reset path is checked on the cycle right after it. A faulty erased-vector capture appears one cycle after the second fetch, as a missing, stretched or spurious int_rst_req.

// File: rtl/monitor_entry_ctrl.sv
module monitor_entry_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              tst_hv,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] rdata,
  input  logic              vec_fetch,
  input  logic              cop_dis_cfg,
  input  logic [1:0]        port_sel,
  output logic [1:0]        mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic              int_rst_req,
  output logic              cop_en,
  output logic              clk_bypass,
  output logic              rst_pin_sel,
  output logic [1:0]        link_mode
);

  localparam logic [1:0] M_USER = 2'b00;
  localparam logic [1:0] M_NMON = 2'b01;
  localparam logic [1:0] M_FORC = 2'b10;

  logic [1:0] mode_q;
  logic       forced_q, armed_q, first_erased_q, pulse_q;

  wire       page_top = &addr_in[ADDR_W-1:8];
  wire [7:0] lo       = addr_in[7:0];
  wire       vec_slot = page_top && (lo[7:2] == 6'h3F);
  wire       in_mon   = (mode_q != M_USER);
  wire       erased   = &rdata;
  wire       rv_hi    = vec_fetch && page_top && (lo == 8'hFE);
  wire       rv_lo    = vec_fetch && page_top && (lo == 8'hFF);
  wire       detect   = (mode_q == M_USER) && armed_q && first_erased_q && rv_lo && erased;
  wire       bypass   = (mode_q == M_NMON) && tst_hv;

  assign addr_out = (in_mon && vec_fetch && vec_slot)
                  ? {addr_in[ADDR_W-1:9], 1'b0, addr_in[7:0]} : addr_in;

  always_ff @(posedge clk) begin
    if (por) begin
      forced_q <= 1'b0;
      mode_q   <= tst_hv ? M_NMON : M_USER;
    end else if (rst) begin
      mode_q   <= tst_hv ? M_NMON : (forced_q ? M_FORC : M_USER);
    end else if (detect) begin
      forced_q <= 1'b1;
      mode_q   <= M_FORC;
    end
  end

  always_ff @(posedge clk) begin
    if (por || rst) begin
      armed_q        <= 1'b0;
      first_erased_q <= 1'b0;
      pulse_q        <= 1'b0;
    end else begin
      armed_q        <= rv_hi && (mode_q == M_USER);
      first_erased_q <= erased;
      pulse_q        <= detect;
    end
  end

  assign mode        = mode_q;
  assign int_rst_req = pulse_q;
  assign clk_bypass  = bypass;
  assign rst_pin_sel = bypass;
  assign cop_en      = (mode_q != M_FORC) && !bypass && !cop_dis_cfg;
  assign link_mode   = !in_mon ? 2'b00 : port_sel[1] ? 2'b10 : port_sel[0] ? 2'b01 : 2'b00;

  // R1
  reset_vec_reloc_chk: assert property (@(posedge clk) disable iff (por || rst)
    (mode != M_USER && vec_fetch && addr_in == 16'hFFFE) |-> addr_out == 16'hFEFE);
  // R3
  user_passthru_chk: assert property (@(posedge clk) disable iff (por || rst)
    (mode == M_USER) |-> addr_out == addr_in);
  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (por || rst)
    int_rst_req |=> !int_rst_req);
  // R5
  req_mode_chk: assert property (@(posedge clk) disable iff (por || rst)
    int_rst_req |-> mode == M_FORC);
  // R6
  forced_keep_chk: assert property (@(posedge clk) disable iff (por)
    forced_q |=> forced_q);
  // R8
  bypass_tst_chk: assert property (@(posedge clk) disable iff (por || rst)
    clk_bypass |-> (tst_hv && rst_pin_sel));
  // R9
  cop_forced_chk: assert property (@(posedge clk) disable iff (por || rst)
    (mode == M_FORC) |-> !cop_en);
  // R10
  link_par_chk: assert property (@(posedge clk) disable iff (por || rst)
    (mode != M_USER && port_sel[1]) |-> link_mode == 2'b10);

endmodule

// File: tb/monitor_entry_ctrl_tb.sv
module monitor_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic por = 1'b1, rst = 1'b0, tst_hv = 1'b0, vec_fetch = 1'b0;
  logic cop_dis_cfg = 1'b0;
  logic [1:0] port_sel = 2'b00;
  logic [15:0] addr_in = 16'h0000;
  logic [7:0] rdata = 8'h00;
  logic [1:0] mode, link_mode;
  logic [15:0] addr_out;
  logic int_rst_req, cop_en, clk_bypass, rst_pin_sel;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  monitor_entry_ctrl dut_i (
    .clk(clk), .por(por), .rst(rst), .tst_hv(tst_hv), .addr_in(addr_in),
    .rdata(rdata), .vec_fetch(vec_fetch), .cop_dis_cfg(cop_dis_cfg),
    .port_sel(port_sel), .mode(mode), .addr_out(addr_out),
    .int_rst_req(int_rst_req), .cop_en(cop_en), .clk_bypass(clk_bypass),
    .rst_pin_sel(rst_pin_sel), .link_mode(link_mode));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_por(input logic t);
    @(negedge clk); por = 1'b1; tst_hv = t;
    @(negedge clk); por = 1'b0;
  endtask

  task automatic do_rst(input logic t);
    @(negedge clk); rst = 1'b1; tst_hv = t;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic fetch_pair(input logic [7:0] d_hi, input logic [7:0] d_lo, input bit gap);
    @(negedge clk); vec_fetch = 1'b1; addr_in = 16'hFFFE; rdata = d_hi;
    if (gap) begin
      @(negedge clk); vec_fetch = 1'b0; addr_in = 16'h1234; rdata = 8'hFF;
    end
    @(negedge clk); vec_fetch = 1'b1; addr_in = 16'hFFFF; rdata = d_lo;
    @(negedge clk); vec_fetch = 1'b0; addr_in = 16'h0000; rdata = 8'h00;
  endtask

  task automatic sweep_reloc(input logic [1:0] m);
    logic [7:0] his [3];
    his[0] = 8'hFF; his[1] = 8'hFE; his[2] = 8'h00;
    rdata = 8'h00;
    for (int v = 0; v < 2; v++)
      for (int h = 0; h < 3; h++)
        for (int l = 0; l < 256; l++) begin
          logic [15:0] a, e;
          bit slot;
          a = {his[h], 8'(l)};
          slot = (his[h] == 8'hFF) && (l >= 8'hFC);
          e = (m != 2'b00 && v == 1 && slot) ? {8'hFE, 8'(l)} : a;
          vec_fetch = 1'(v); addr_in = a;
          #1;
          if (slot && l >= 8'hFE) chk("R1", "addr_out", addr_out, e);
          else if (slot) chk("R2", "addr_out", addr_out, e);
          else chk("R3", "addr_out", addr_out, e);
        end
    vec_fetch = 1'b0; addr_in = 16'h0000;
  endtask

  task automatic sweep_ctrl(input logic [1:0] m);
    for (int t = 0; t < 2; t++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 4; s++) begin
          bit byp, cop;
          int lk;
          tst_hv = 1'(t); cop_dis_cfg = 1'(c); port_sel = 2'(s);
          #1;
          byp = (m == 2'b01) && (t == 1);
          cop = (m != 2'b10) && !byp && (c == 0);
          lk  = (m == 2'b00) ? 0 : (s >= 2) ? 2 : (s == 1) ? 1 : 0;
          chk("R8", "clk_bypass", clk_bypass, int'(byp));
          chk("R8", "rst_pin_sel", rst_pin_sel, int'(byp));
          chk("R9", "cop_en", cop_en, int'(cop));
          chk("R10", "link_mode", link_mode, lk);
          chk("R4", "mode stable", mode, m);
        end
    tst_hv = 1'b0; cop_dis_cfg = 1'b0; port_sel = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por = 1'b0;
    #1;
    chk("R4", "por user mode", mode, 0);
    chk("R5", "no req after por", int_rst_req, 0);
    chk("R9", "cop after por", cop_en, 1);
    chk("R10", "link after por", link_mode, 0);

    sweep_reloc(2'b00);
    sweep_ctrl(2'b00);

    fetch_pair(8'hFF, 8'hFE, 0);
    chk("R5", "hi only erased req", int_rst_req, 0);
    chk("R5", "hi only erased mode", mode, 0);
    fetch_pair(8'h7F, 8'hFF, 0);
    chk("R5", "lo only erased req", int_rst_req, 0);
    chk("R5", "lo only erased mode", mode, 0);
    fetch_pair(8'hFF, 8'hFF, 1);
    chk("R5", "gap req", int_rst_req, 0);
    chk("R5", "gap mode", mode, 0);
    fetch_pair(8'hFF, 8'hFF, 0);
    chk("R5", "erased req", int_rst_req, 1);
    chk("R5", "erased mode", mode, 2);
    @(negedge clk);
    chk("R5", "req one cycle", int_rst_req, 0);

    sweep_reloc(2'b10);
    sweep_ctrl(2'b10);
    fetch_pair(8'hFF, 8'hFF, 0);
    chk("R5", "no req in forced", int_rst_req, 0);

    do_rst(1'b0);
    chk("R6", "rst keeps forced", mode, 2);
    chk("R5", "req cleared by rst", int_rst_req, 0);

    do_rst(1'b1);
    chk("R7", "tst wins at rst", mode, 1);
    chk("R8", "bypass with tst", clk_bypass, 1);
    chk("R9", "cop off with tst", cop_en, 0);
    sweep_reloc(2'b01);
    sweep_ctrl(2'b01);
    #1;
    chk("R8", "bypass released", clk_bypass, 0);
    chk("R9", "cop back to cfg", cop_en, 1);
    do_rst(1'b0);
    chk("R7", "forced back after nmon", mode, 2);

    do_por(1'b0);
    #1;
    chk("R6", "por clears forced", mode, 0);
    do_rst(1'b0);
    chk("R6", "rst after por user", mode, 0);
    do_por(1'b1);
    chk("R4", "por with tst", mode, 1);
    tst_hv = 1'b0;
    do_rst(1'b0);
    chk("R6", "flag gone after por", mode, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule